// File: doc/BRIEF.md
# Byte-Lane Static RAM Model with Control Decode

This block is a clocked model of a 16-bit static RAM controlled by active-low strobes: chip select, write enable, output enable and one enable for each byte lane. At every rising clock edge it samples the strobes, the address and the write data, and it classifies the cycle as standby, output-disabled, read or write. It then performs a write on the enabled byte lanes only, or a read on the enabled byte lanes only. Read data, the per-lane drive flags and the mode code all appear one clock after sampling. After reset the block runs a power-up initialisation interval of `INIT_CYC` clocks. During that interval it ignores every access, and it raises `ready` when the interval ends.

A single state machine holds the mode of the last sampled cycle. Its states are S_BOOT (initialisation), S_IDLE (standby), S_DARK (active but not driving), S_READ and S_WRITE. Reset enters S_BOOT. S_BOOT moves to S_IDLE at the edge where the boot counter reaches `INIT_CYC-1`. From S_IDLE, S_DARK, S_READ and S_WRITE, every edge moves to the state that the sampled strobes decode to. The decode is applied in this order:
- chip select high gives S_IDLE;
- both lane enables high gives S_DARK;
- write enable low gives S_WRITE;
- output enable high gives S_DARK;
- anything else gives S_READ.

Each byte lane is a separate storage bank.

Top module: `lane_sram`

## Requirements
- R1: With `cs_n` high at a sampled edge, the next cycle shows `mode`=00, `lane_drv`=00 and `rdata`=0, and no lane is stored, whatever the other strobes are.
- R2: With `cs_n` and `we_n` low and at least one lane enable low, the next cycle shows `mode`=11 and `lane_drv`=00, even when `oe_n` is low.
- R3: During a write, `lb_n` low stores `wdata[7:0]` and `ub_n` low stores `wdata[15:8]` at `addr`. A lane whose enable is high keeps its previous byte.
- R4: With `cs_n` low, `we_n` high, `oe_n` low and at least one lane enable low, the next cycle shows `mode`=10, `lane_drv[0]`=!`lb_n`, `lane_drv[1]`=!`ub_n`, and the stored bytes of the driven lanes on `rdata`.
- R5: With `cs_n` low and either both lane enables high or (`we_n` high and `oe_n` high), the next cycle shows `mode`=01 and `lane_drv`=00, and nothing is stored.
- R6: After reset is released, `ready` stays low through edge `INIT_CYC-1`, goes high at edge `INIT_CYC`, and then stays high until the next reset.
- R7: Accesses sampled while `ready` is low are ignored. `mode` reads 00, `lane_drv` reads 00 and memory is not written. Memory contents survive a reset.
- R8: Results follow the sampling edge by exactly one clock. A write followed by a read of the same address on the next edge returns the new data.
- R9: An undriven lane always reads zero on its `rdata` byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low byte lane enable, active low |
| ub_n | input | 1 | High byte lane enable, active low |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| lane_drv | output | 2 | Per-lane drive flag (bit 0 low byte, bit 1 high byte) |
| ready | output | 1 | Initialisation complete |
| mode | output | 2 | 00 standby, 01 output-disabled, 10 read, 11 write |

## Verification
The hardest case to show is that a write attempted during initialisation leaves memory untouched. Memory has no reset value, so a fresh start offers nothing to compare against. The stimulus therefore first stores a known word after `ready` rises. It then applies a second reset and holds a full-word write of different data to the same address throughout the new boot interval. Once `ready` returns, it reads that address back and expects the original word. The exact rising edge of `ready` is also checked, by counting edges from the release of reset.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        MD_STBY  = 2'b00,
        MD_DARK  = 2'b01,
        MD_READ  = 2'b10,
        MD_WRITE = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        S_BOOT,
        S_IDLE,
        S_DARK,
        S_READ,
        S_WRITE
    } state_e;
endpackage

// File: rtl/lane_sram_ctl.sv
module lane_sram_ctl
    import lane_sram_pkg::*;
#(
    parameter int INIT_CYC = 7500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    output logic             ready,
    output logic [1:0]       mode,
    output logic [LANES-1:0] lane_drv,
    output logic [LANES-1:0] wr_lanes,
    output logic [LANES-1:0] rd_lanes
);
    localparam int CW = $clog2(INIT_CYC + 1);

    state_e           state_q, state_d, access_st;
    logic [CW-1:0]    cnt_q;
    logic [LANES-1:0] drv_q;
    logic             running;

    // Access decode, in priority order
    always_comb begin
        if (cs_n)            access_st = S_IDLE;
        else if (&be_n)      access_st = S_DARK;
        else if (!we_n)      access_st = S_WRITE;
        else if (oe_n)       access_st = S_DARK;
        else                 access_st = S_READ;
    end

    assign running  = (state_q != S_BOOT);
    assign wr_lanes = (running && access_st == S_WRITE) ? ~be_n : '0;
    assign rd_lanes = (running && access_st == S_READ)  ? ~be_n : '0;

    always_comb begin
        unique case (state_q)
            S_BOOT:  state_d = (cnt_q == CW'(INIT_CYC - 1)) ? S_IDLE : S_BOOT;
            S_IDLE,
            S_DARK,
            S_READ,
            S_WRITE: state_d = access_st;
            default: state_d = S_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
            cnt_q   <= '0;
            drv_q   <= '0;
        end else begin
            state_q <= state_d;
            drv_q   <= rd_lanes;
            if (state_q == S_BOOT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        lane_drv = '0;
        ready    = running;
        unique case (state_q)
            S_BOOT,
            S_IDLE:  mode = MD_STBY;
            S_DARK:  mode = MD_DARK;
            S_READ: begin
                mode     = MD_READ;
                lane_drv = drv_q;
            end
            S_WRITE: mode = MD_WRITE;
            default: mode = MD_STBY;
        endcase
    end

    p_boot_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (mode == MD_STBY && lane_drv == '0));

    p_ready_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && $past(cs_n)) |-> (mode == MD_STBY && lane_drv == '0));

    p_write_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && $past(!cs_n && !we_n && !(&be_n)))
            |-> (mode == MD_WRITE && lane_drv == '0));

    p_drive_follows_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READ) |-> (lane_drv == ~$past(be_n)));

    p_no_store_in_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lanes != '0) |-> ready);
endmodule

// File: rtl/lane_sram_lane.sv
module lane_sram_lane
    import lane_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [LANE_W-1:0] wd,
    output logic [LANE_W-1:0] rd_q
);
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[addr];
        else            rd_q <= '0;
    end
endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter  int DEPTH    = 256,
    parameter  int INIT_CYC = 7500,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  lane_drv,
    output logic              ready,
    output logic [1:0]        mode
);
    logic [LANES-1:0] wr_lanes, rd_lanes;

    lane_sram_ctl #(.INIT_CYC(INIT_CYC)) ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .be_n     ({ub_n, lb_n}),
        .ready    (ready),
        .mode     (mode),
        .lane_drv (lane_drv),
        .wr_lanes (wr_lanes),
        .rd_lanes (rd_lanes)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_sram_lane #(.DEPTH(DEPTH), .AW(AW)) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_lanes[g]),
            .rd_en (rd_lanes[g]),
            .addr  (addr),
            .wd    (wdata[g*LANE_W +: LANE_W]),
            .rd_q  (rdata[g*LANE_W +: LANE_W])
        );

        p_quiet_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_drv[g] |-> (rdata[g*LANE_W +: LANE_W] == '0));
    end
endmodule

// File: tb/lane_sram_tb_top.sv
module lane_sram_tb_top;
    localparam int INIT_CYC = 40;
    localparam int DEPTH    = 256;

    typedef struct packed {
        logic        cs_n, we_n, oe_n, lb_n, ub_n;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic [1:0]  md;
        logic [1:0]  drv;
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'h10, 16'hA5C3, 2'b11, 2'b00, 16'h0000}, // R2 write, oe low
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h10, 16'h0000, 2'b10, 2'b11, 16'hA5C3}, // R4 full read
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 8'h10, 16'h1177, 2'b11, 2'b00, 16'h0000}, // R3 low lane write
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h10, 16'h0000, 2'b10, 2'b11, 16'hA577}, // R3
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'h10, 16'h88FF, 2'b11, 2'b00, 16'h0000}, // R3 high lane write
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h10, 16'h0000, 2'b10, 2'b11, 16'h8877}, // R3
        '{1'b0,1'b1,1'b0,1'b0,1'b1, 8'h10, 16'h0000, 2'b10, 2'b01, 16'h0077}, // R4 R9 low only
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 8'h10, 16'h0000, 2'b10, 2'b10, 16'h8800}, // R4 R9 high only
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'h10, 16'h0000, 2'b01, 2'b00, 16'h0000}, // R5 oe high
        '{1'b0,1'b1,1'b0,1'b1,1'b1, 8'h10, 16'h0000, 2'b01, 2'b00, 16'h0000}, // R5 no lanes
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 8'h10, 16'hFFFF, 2'b01, 2'b00, 16'h0000}, // R5 write no lanes
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h10, 16'h0000, 2'b10, 2'b11, 16'h8877}, // R5 unchanged
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'h10, 16'h0000, 2'b00, 2'b00, 16'h0000}, // R1 standby
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h10, 16'h0000, 2'b10, 2'b11, 16'h8877}, // R1 unchanged
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'h20, 16'h1234, 2'b11, 2'b00, 16'h0000}, // R8
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h20, 16'h0000, 2'b10, 2'b11, 16'h1234}, // R8 back to back
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'h30, 16'h0F0F, 2'b11, 2'b00, 16'h0000}, // R7 setup
        '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h30, 16'h0000, 2'b10, 2'b11, 16'h0F0F}  // R7 setup
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  lane_drv;
    logic        ready;
    logic [1:0]  mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lane_sram #(.DEPTH(DEPTH), .INIT_CYC(INIT_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lane_drv(lane_drv), .ready(ready), .mode(mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, w, o, l, u, input logic [7:0] a, input logic [15:0] d);
        cs_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; wdata = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check("R6 reset ready", 32'(ready), 32'd0);
        check("R7 reset mode", 32'(mode), 32'd0);
        check("R9 reset rdata", 32'(rdata), 32'd0);

        // first boot with a read held on the pins
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10, 16'h0000);
        rst_n = 1'b1;
        repeat (INIT_CYC - 1) @(posedge clk);
        @(negedge clk);
        check("R6 ready low at INIT_CYC-1", 32'(ready), 32'd0);
        check("R7 read in boot mode", 32'(mode), 32'd0);
        check("R7 read in boot drv", 32'(lane_drv), 32'd0);
        @(negedge clk);
        check("R6 ready high at INIT_CYC", 32'(ready), 32'd1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0000);
        @(negedge clk);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cs_n, VECS[i].we_n, VECS[i].oe_n, VECS[i].lb_n, VECS[i].ub_n,
                  VECS[i].addr, VECS[i].wd);
            @(negedge clk);
            check($sformatf("vec %0d mode", i), 32'(mode), 32'(VECS[i].md));
            check($sformatf("vec %0d lane_drv", i), 32'(lane_drv), 32'(VECS[i].drv));
            check($sformatf("vec %0d rdata", i), 32'(rdata), 32'(VECS[i].rd));
        end
        check("R6 ready held", 32'(ready), 32'd1);

        // R7: second reset, write attempted throughout boot must not land
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30, 16'hDEAD);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (INIT_CYC - 1) @(negedge clk);
        check("R7 write in boot mode", 32'(mode), 32'd0);
        @(negedge clk);
        check("R6 ready after second boot", 32'(ready), 32'd1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h30, 16'h0000);
        @(negedge clk);
        check("R7 boot write ignored", 32'(rdata), 32'h0F0F);
        check("R4 read mode after boot", 32'(mode), 32'd2);

        // R1: standby one cycle after a read clears drive and data
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h30, 16'h0000);
        @(negedge clk);
        check("R1 standby drv", 32'(lane_drv), 32'd0);
        check("R1 standby rdata", 32'(rdata), 32'd0);
        finish_run();
    end
endmodule